// File: doc/BRIEF.md
# Masked Color Fill Write Engine

This block holds a small on-chip storage array of `ROWS` rows, 512 columns and 4 I/O bits per column. It writes the contents of a 4-bit color register into that array in bulk. A command port carries one already-classified command per clock: load the color register, fill a whole row, or fill an aligned group of four columns. Decoding the strobes that classify a memory cycle is done upstream. This block receives the cycle type together with the values that would be on the data lines at the row and column strobe events.

A row fill writes the color into every column of the chosen row. Only the I/O bits enabled by a row-time I/O mask are changed. The fill walks the row `LANES` columns per clock and raises a busy flag until the whole row is done. A group fill takes the upper seven column address bits as a group number. It writes the color into the four columns of that group in the same clock that accepts the command. Each of the four columns is gated by one bit of a column mask. The I/O bits are gated by the row-time I/O mask, but only when the command enables it. A combinational read port returns any stored word.

Top module: `colorfill_engine`

## Requirements
- R1: After reset, `busy` is 0, `color_value` is 0 and every stored word reads 0.
- R2: An accepted command with `cmd_op` = 1 (load color) sets `color_value` to `cmd_color` after that clock edge. Encodings: 0 = no operation, 1 = load color, 2 = row fill, 3 = group fill.
- R3: An accepted row fill (`cmd_op` = 2) raises `busy` after its edge. `busy` stays high for exactly 512/`LANES` clocks (64 by default). After that, every column of row `cmd_row` holds the color in the enabled I/O bits.
- R4: In a row fill, bit b of `cmd_io_mask` equal to 1 lets I/O bit b be written. Bits whose mask bit is 0 keep their old value.
- R5: A fill changes no word outside its target row, and a group fill changes no column outside its group.
- R6: An accepted group fill (`cmd_op` = 3) writes columns 4·`cmd_col_grp` + i (i = 0..3) at the accepting edge. The result is readable right after that edge, and `busy` stays 0.
- R7: In a group fill, bit i of `cmd_col_mask` equal to 1 enables the column whose two low address bits equal i. A column whose bit is 0 is left unchanged.
- R8: In a group fill, `cmd_io_mask` gates the I/O bits (1 = write) only when `cmd_io_mask_on` is 1. When `cmd_io_mask_on` is 0, all four I/O bits are written.
- R9: While `busy` is 1, every command is ignored. A color load leaves `color_value` unchanged and a group fill changes no stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this clock |
| cmd_op | input | 2 | Command type: 0 none, 1 load color, 2 row fill, 3 group fill |
| cmd_row | input | ROW_W | Target row for fills |
| cmd_col_grp | input | 7 | Column group (upper column address bits) for group fill |
| cmd_io_mask | input | 4 | I/O write mask, 1 = write |
| cmd_io_mask_on | input | 1 | Group fill: apply `cmd_io_mask` when 1 |
| cmd_col_mask | input | 4 | Group fill column enables, bit i = column with low bits i |
| cmd_color | input | 4 | New color register value for load color |
| busy | output | 1 | Row fill in progress |
| color_value | output | 4 | Current color register contents |
| rd_row | input | ROW_W | Read row address |
| rd_col | input | 9 | Read column address |
| rd_data | output | 4 | Stored word at (`rd_row`, `rd_col`), combinational |

## Verification
A color load and a group fill take effect at the edge that accepts them. The bench drives each command half a period before that edge and reads the result on the following falling edge. A row fill's result is due 64 edges after acceptance. The bench counts falling edges with `busy` high, expects exactly 64, and reads the array only once `busy` has dropped. Array reads are combinational, so the bench compares the whole array through the read port against a bench-side model while no command is pending.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

  localparam int IO_W  = 4;
  localparam int COL_W = 9;
  localparam int BLK_W = 2;
  localparam int GRP_W = COL_W - BLK_W;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_LOAD  = 2'd1,
    OP_FLASH = 2'd2,
    OP_BLOCK = 2'd3
  } op_e;

  // Per-bit merge: enabled bits take the color, others keep the old value.
  function automatic logic [IO_W-1:0] io_merge(input logic [IO_W-1:0] old_w,
                                               input logic [IO_W-1:0] color,
                                               input logic [IO_W-1:0] en);
    return (old_w & ~en) | (color & en);
  endfunction

  // Group fill hit: column lies in the group and its mask bit is set.
  function automatic logic blk_hit(input logic [COL_W-1:0] col,
                                   input logic [GRP_W-1:0] grp,
                                   input logic [3:0]       cmask);
    return (col[COL_W-1:BLK_W] == grp) && cmask[col[BLK_W-1:0]];
  endfunction

  // Row fill hit: column lies in the chunk selected by the sequencer.
  function automatic logic flash_hit(input logic [COL_W-1:0] col,
                                     input int unsigned      chunk,
                                     input int unsigned      lane_w);
    int unsigned c;
    c = 32'(col);
    return (c >> lane_w) == chunk;
  endfunction

endpackage

// File: rtl/cfe_color_reg.sv
module cfe_color_reg import cfe_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IO_W-1:0] din,
  output logic [IO_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/cfe_flash_seq.sv
module cfe_flash_seq import cfe_pkg::*; #(
  parameter int CHUNKS  = 64,
  parameter int ROW_W   = 2,
  localparam int CHK_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] row_in,
  input  logic [IO_W-1:0]  mask_in,
  output logic             busy,
  output logic             fire,
  output logic [CHK_W-1:0] chunk,
  output logic [ROW_W-1:0] row,
  output logic [IO_W-1:0]  mask
);
  localparam logic [CHK_W-1:0] LAST = CHK_W'(CHUNKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      chunk <= '0;
      row   <= '0;
      mask  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      chunk <= '0;
      row   <= row_in;
      mask  <= mask_in;
    end else if (busy) begin
      if (chunk == LAST) busy <= 1'b0;
      else               chunk <= chunk + 1'b1;
    end
  end

  assign fire = busy;
endmodule

// File: rtl/cfe_array.sv
module cfe_array import cfe_pkg::*; #(
  parameter int ROWS   = 4,
  parameter int ROW_W  = 2,
  localparam int COLS  = 1 << COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COLS-1:0]  col_en,
  input  logic [IO_W-1:0]  io_en,
  input  logic [IO_W-1:0]  color,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [COL_W-1:0] rd_col,
  output logic [IO_W-1:0]  rd_data
);
  logic [IO_W-1:0] mem [ROWS][COLS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem[r][c] <= '0;
    end else if (we) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          if (wr_row == ROW_W'(r) && col_en[c])
            mem[r][c] <= io_merge(mem[r][c], color, io_en);
    end
  end

  assign rd_data = mem[rd_row][rd_col];
endmodule

// File: rtl/colorfill_engine.sv
module colorfill_engine import cfe_pkg::*; #(
  parameter int ROWS  = 4,
  parameter int LANES = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [GRP_W-1:0] cmd_col_grp,
  input  logic [IO_W-1:0]  cmd_io_mask,
  input  logic             cmd_io_mask_on,
  input  logic [3:0]       cmd_col_mask,
  input  logic [IO_W-1:0]  cmd_color,
  output logic             busy,
  output logic [IO_W-1:0]  color_value,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [COL_W-1:0] rd_col,
  output logic [IO_W-1:0]  rd_data
);
  localparam int COLS   = 1 << COL_W;
  localparam int CHUNKS = COLS / LANES;
  localparam int LANE_W = $clog2(LANES);
  localparam int CHK_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;

  // Named internal events
  logic             cmd_accept;
  logic             load_go, flash_go, block_go;
  logic             flash_fire;
  logic [CHK_W-1:0] flash_chunk;
  logic [ROW_W-1:0] flash_row;
  logic [IO_W-1:0]  flash_mask;
  logic             wr_we;
  logic [ROW_W-1:0] wr_row;
  logic [COLS-1:0]  wr_col_en;
  logic [IO_W-1:0]  wr_io_en;

  assign cmd_accept = cmd_valid && !busy;
  assign load_go    = cmd_accept && (op_e'(cmd_op) == OP_LOAD);
  assign flash_go   = cmd_accept && (op_e'(cmd_op) == OP_FLASH);
  assign block_go   = cmd_accept && (op_e'(cmd_op) == OP_BLOCK);

  cfe_color_reg u_color (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load_go),
    .din  (cmd_color),
    .q    (color_value)
  );

  cfe_flash_seq #(.CHUNKS(CHUNKS), .ROW_W(ROW_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (flash_go),
    .row_in (cmd_row),
    .mask_in(cmd_io_mask),
    .busy   (busy),
    .fire   (flash_fire),
    .chunk  (flash_chunk),
    .row    (flash_row),
    .mask   (flash_mask)
  );

  // Write port steering: the sequencer owns the port while busy,
  // so a group fill can never coincide with a row fill chunk.
  assign wr_we = flash_fire || block_go;

  always_comb begin
    wr_col_en = '0;
    if (flash_fire) begin
      wr_row   = flash_row;
      wr_io_en = flash_mask;
      for (int c = 0; c < COLS; c++)
        wr_col_en[c] = flash_hit(COL_W'(c), 32'(flash_chunk), LANE_W);
    end else begin
      wr_row   = cmd_row;
      wr_io_en = cmd_io_mask_on ? cmd_io_mask : '1;
      for (int c = 0; c < COLS; c++)
        wr_col_en[c] = blk_hit(COL_W'(c), cmd_col_grp, cmd_col_mask);
    end
  end

  cfe_array #(.ROWS(ROWS), .ROW_W(ROW_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_we),
    .wr_row (wr_row),
    .col_en (wr_col_en),
    .io_en  (wr_io_en),
    .color  (color_value),
    .rd_row (rd_row),
    .rd_col (rd_col),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/colorfill_engine_chk.sv
module colorfill_engine_chk import cfe_pkg::*; #(
  parameter int COLS  = 512,
  parameter int LANES = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic [IO_W-1:0] cmd_io_mask,
  input logic            cmd_io_mask_on,
  input logic [3:0]      cmd_col_mask,
  input logic [IO_W-1:0] cmd_color,
  input logic            busy,
  input logic [IO_W-1:0] color_value,
  input logic            flash_fire,
  input logic            wr_we,
  input logic [COLS-1:0] wr_col_en,
  input logic [IO_W-1:0] wr_io_en
);
  localparam int CHUNKS = COLS / LANES;
  localparam int CNT_W  = $clog2(CHUNKS) + 2;

  logic free_load, free_flash, free_block;
  assign free_load  = cmd_valid && !busy && cmd_op == 2'd1;
  assign free_flash = cmd_valid && !busy && cmd_op == 2'd2;
  assign free_block = cmd_valid && !busy && cmd_op == 2'd3;

  // Busy-length counter (window too long for $past)
  logic [CNT_W-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_cnt <= '0;
    else if (free_flash) busy_cnt <= '0;
    else if (busy)       busy_cnt <= busy_cnt + 1'b1;
  end

  a_r2_load_color: assert property (@(posedge clk) disable iff (!rst_n)
    free_load |=> color_value == $past(cmd_color));

  a_r3_flash_starts: assert property (@(posedge clk) disable iff (!rst_n)
    free_flash |=> busy);

  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == CNT_W'(CHUNKS));

  a_r3_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    flash_fire |-> $countones(wr_col_en) == LANES);

  a_r4_flash_io: assert property (@(posedge clk) disable iff (!rst_n)
    free_flash ##1 flash_fire |-> wr_io_en == $past(cmd_io_mask));

  a_r6_block_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    free_block |=> !busy);

  a_r7_col_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_we && !flash_fire) |-> $countones(wr_col_en) == $countones(cmd_col_mask));

  a_r8_io_all: assert property (@(posedge clk) disable iff (!rst_n)
    (free_block && !cmd_io_mask_on) |-> wr_io_en == '1);

  a_r9_busy_color: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(color_value));

  a_r9_busy_no_block: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |-> (wr_we == flash_fire));
endmodule

bind colorfill_engine colorfill_engine_chk #(.COLS(COLS), .LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .cmd_io_mask   (cmd_io_mask),
  .cmd_io_mask_on(cmd_io_mask_on),
  .cmd_col_mask  (cmd_col_mask),
  .cmd_color     (cmd_color),
  .busy          (busy),
  .color_value   (color_value),
  .flash_fire    (flash_fire),
  .wr_we         (wr_we),
  .wr_col_en     (wr_col_en),
  .wr_io_en      (wr_io_en)
);

// File: tb/colorfill_engine_test.sv
`timescale 1ns/1ps
module colorfill_engine_test;
  localparam int NR = 4;
  localparam int NC = 512;
  localparam int FILL_CLKS = NC / 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [1:0] cmd_row = '0;
  logic [6:0] cmd_col_grp = '0;
  logic [3:0] cmd_io_mask = '0;
  logic       cmd_io_mask_on = 1'b0;
  logic [3:0] cmd_col_mask = '0;
  logic [3:0] cmd_color = '0;
  logic       busy;
  logic [3:0] color_value;
  logic [1:0] rd_row = '0;
  logic [8:0] rd_col = '0;
  logic [3:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] model [NR][NC];
  logic [3:0] color_m = '0;

  always #10 clk = ~clk;

  colorfill_engine #(.ROWS(NR), .LANES(8)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .cmd_col_grp(cmd_col_grp), .cmd_io_mask(cmd_io_mask),
    .cmd_io_mask_on(cmd_io_mask_on), .cmd_col_mask(cmd_col_mask),
    .cmd_color(cmd_color), .busy(busy), .color_value(color_value),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] mix(input logic [3:0] o, input logic [3:0] c, input logic [3:0] m);
    logic [3:0] n;
    for (int b = 0; b < 4; b++) n[b] = m[b] ? c[b] : o[b];
    return n;
  endfunction

  // Full array compare through the read port (no command pending)
  task automatic cmp_all(input string req);
    int bad = 0;
    logic [3:0] a = '0, e = '0;
    int br = 0, bc = 0;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        rd_row = 2'(r); rd_col = 9'(c); #1;
        if (rd_data !== model[r][c] && bad == 0) begin
          a = rd_data; e = model[r][c]; br = r; bc = c; bad = 1;
        end
      end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: row %0d col %0d actual %0h expected %0h", req, br, bc, a, e);
    end
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input int row, input int grp,
                       input logic [3:0] iom, input logic on,
                       input logic [3:0] cm, input logic [3:0] col);
    cmd_valid = 1'b1; cmd_op = op; cmd_row = 2'(row); cmd_col_grp = 7'(grp);
    cmd_io_mask = iom; cmd_io_mask_on = on; cmd_col_mask = cm; cmd_color = col;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic load(input logic [3:0] col);
    issue(2'd1, 0, 0, 4'h0, 1'b0, 4'h0, col);
    color_m = col;
  endtask

  task automatic flash(input int row, input logic [3:0] iom, input string req);
    int n = 0;
    issue(2'd2, row, 0, iom, 1'b0, 4'h0, 4'h0);
    for (int c = 0; c < NC; c++) model[row][c] = mix(model[row][c], color_m, iom);
    while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    check(n == FILL_CLKS, req, n, FILL_CLKS);
  endtask

  task automatic block(input int row, input int grp, input logic [3:0] iom,
                       input logic on, input logic [3:0] cm);
    issue(2'd3, row, grp, iom, on, cm, 4'h0);
    for (int i = 0; i < 4; i++)
      if (cm[i]) model[row][grp*4+i] = mix(model[row][grp*4+i], color_m, on ? iom : 4'hF);
  endtask

  initial begin
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) model[r][c] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(color_value == 4'h0, "R1 color", int'(color_value), 0);
    cmp_all("R1 array zero");

    // R2 color load
    load(4'h5);
    check(color_value == 4'h5, "R2 load", int'(color_value), 5);
    load(4'hA);
    check(color_value == 4'hA, "R2 reload", int'(color_value), 10);

    // R3 full row fill, R5 other rows untouched
    load(4'h5);
    flash(1, 4'hF, "R3 busy length");
    cmp_all("R3 R5 row fill");

    // R4 sweep of all I/O masks across rows
    for (int m = 0; m < 16; m++) begin
      load(4'((m * 7 + 3) % 16));
      flash(m % NR, 4'(m), "R4 busy length");
    end
    cmp_all("R4 masked row fills");

    // R9 commands ignored while busy
    load(4'h6);
    issue(2'd2, 0, 0, 4'hF, 1'b0, 4'h0, 4'h0);
    for (int c = 0; c < NC; c++) model[0][c] = 4'h6;
    check(busy == 1'b1, "R9 busy set", int'(busy), 1);
    issue(2'd1, 0, 0, 4'h0, 1'b0, 4'h0, 4'h9);
    check(color_value == 4'h6, "R9 load ignored", int'(color_value), 6);
    issue(2'd3, 3, 5, 4'hF, 1'b0, 4'hF, 4'h0);
    issue(2'd2, 2, 0, 4'hF, 1'b0, 4'h0, 4'h0);
    while (busy === 1'b1) @(negedge clk);
    check(color_value == 4'h6, "R9 color kept", int'(color_value), 6);
    cmp_all("R9 ignored fills");

    // R6 R7 R8 group fill sweep over every group of row 2
    for (int g = 0; g < 128; g++) begin
      load(4'((g * 5 + 1) % 16));
      block(2, g, 4'((g / 8) % 16), (g % 3) != 0, 4'(g % 16));
      check(busy == 1'b0, "R6 no busy", int'(busy), 0);
      rd_row = 2'd2; rd_col = 9'(g * 4 + 1); #1;
      check(rd_data === model[2][g*4+1], "R6 R7 R8 immediate", int'(rd_data), int'(model[2][g*4+1]));
      @(negedge clk);
    end
    cmp_all("R6 R7 R8 group sweep");

    // Boundary: last group, all columns, I/O mask off; then mask on with zero mask
    load(4'hC);
    block(3, 127, 4'h0, 1'b0, 4'hF);
    cmp_all("R8 mask off writes all bits");
    load(4'h3);
    block(3, 127, 4'h0, 1'b1, 4'hF);
    cmp_all("R8 zero mask writes nothing");
    block(0, 0, 4'hF, 1'b1, 4'h0);
    cmp_all("R7 zero column mask");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule